// File: doc/BRIEF.md
# Crystal and PLL Enable Controller

This block sits in a clock and reset unit and decides, cycle by cycle, whether the main crystal oscillator and two PLLs are asked to run. Each source has an enable output that drives the analog circuit. The crystal and PLL1 can each be handed from a hardware power-management request to software through a per-source override bit. PLL2 answers only to its software enable bit.

A small APB-style register bus gives software access to these registers:
- a crystal control register;
- a PLL control register;
- a frequency register holding the PLL multiplier and divider codes;
- a lock-count register.

For each source a running indication is produced inside the block. It rises once the enable has been held for the programmed number of cycles, and it drops one cycle after the enable goes away. The frequency codes are also decoded into effective multiplier and shift outputs for the PLL wrappers.

Top module: `osc_pll_ctrl`

## Requirements
- R1: After reset the crystal control register reads 0x0000_0002 with bit 2 masked (override 0, enable 1), the PLL control register reads 0x0000_0002 with bits 2 and 30 masked, the frequency register reads 0, the lock-count register reads the LOCK_RST parameter, pll2_en is 0 and both multiplier outputs are 2.
- R2: Crystal register at 0x0C, override bit 0, enable bit 1. One cycle after the register or hw_xtal_req changes, xtal_en equals the enable bit when override is 1. When override is 0, xtal_en equals hw_xtal_req OR the enable bit, so software can force the crystal on but cannot turn it off.
- R3: PLL register at 0x10, PLL1 override bit 0, PLL1 enable bit 1. One cycle after a change, pll1_en equals the enable bit when override is 1 and equals hw_pll1_req when override is 0.
- R4: pll2_en equals PLL register bit 28 one cycle after it is written, whatever the override bits or hardware requests are.
- R5: Running bits are crystal register bit 2, PLL register bit 2 (PLL1) and PLL register bit 30 (PLL2). A running bit is set max(L,1) cycles after its enable output rises, provided the enable stays high, where L is the lock count. It clears one cycle after the enable output falls.
- R6: Writes to the running bits have no effect on them.
- R7: Frequency register at 0x14: PLL1 multiplier code in bits 13:8, PLL1 shift in bits 2:0, PLL2 multiplier code in bits 29:24. One cycle after a write, pll1_mul is code+2, pll1_shift equals the shift field, and pll2_mul is code+2.
- R8: Crystal register bit 19 drives osc2_dis, bit 20 drives xtal_timer_en, and PLL register bit 29 drives pll_timer_en. All three read back.
- R9: The lock-count register is at 0x18, bits LOCK_W-1:0. It is writable and reads back.
- R10: Unmapped addresses read 0 and writes to them change nothing. Bits with no function read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write strobe |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, registered while psel is high and pwrite is low |
| hw_xtal_req | input | 1 | Power-management request for the crystal |
| hw_pll1_req | input | 1 | Power-management request for PLL1 |
| xtal_en | output | 1 | Crystal enable |
| pll1_en | output | 1 | PLL1 enable |
| pll2_en | output | 1 | PLL2 enable |
| osc2_dis | output | 1 | Secondary oscillator disable |
| xtal_timer_en | output | 1 | Crystal timer enable |
| pll_timer_en | output | 1 | PLL timer enable |
| pll1_mul | output | 7 | PLL1 effective multiplier |
| pll1_shift | output | 3 | PLL1 output right shift |
| pll2_mul | output | 7 | PLL2 effective multiplier |

## Verification
The bench builds the block with LOCK_W=4 and LOCK_RST=3. With these values it can step through every lock count from 0 up to the saturating value 15 for both hardware-driven sources. It measures the exact cycle at which each running bit rises and falls. The 6-bit multiplier codes are swept over all 64 values, and every combination of override, enable and hardware request is applied to each source.

// File: rtl/opc_pkg.sv
package opc_pkg;
  localparam int DW = 32;
  localparam int NSRC = 3;
  localparam int SRC_XTAL = 0;
  localparam int SRC_PLL1 = 1;
  localparam int SRC_PLL2 = 2;

  localparam int OFS_XTAL = 'h0C;
  localparam int OFS_PLL  = 'h10;
  localparam int OFS_FREQ = 'h14;
  localparam int OFS_LOCK = 'h18;

  localparam int B_OVR      = 0;
  localparam int B_EN       = 1;
  localparam int B_RUN      = 2;
  localparam int B_OSC2_DIS = 19;
  localparam int B_XTMR     = 20;
  localparam int B_PLL2_EN  = 28;
  localparam int B_PTMR     = 29;
  localparam int B_PLL2_RUN = 30;

  localparam int MW = 6;
  localparam int SW = 3;
  localparam int F_M1 = 8;
  localparam int F_D1 = 0;
  localparam int F_M2 = 24;

  typedef struct packed {
    logic ovr;
    logic en;
    logic osc2_dis;
    logic tmr_en;
  } xtal_ctl_t;

  typedef struct packed {
    logic ovr;
    logic en;
    logic pll2_en;
    logic tmr_en;
  } pll_ctl_t;

  typedef struct packed {
    logic [MW-1:0] m1;
    logic [SW-1:0] d1;
    logic [MW-1:0] m2;
  } freq_t;
endpackage

// File: rtl/opc_regs.sv
module opc_regs
  import opc_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int LOCK_W   = 8,
  parameter int LOCK_RST = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DW-1:0]     pwdata,
  input  logic [NSRC-1:0]   run,
  output xtal_ctl_t         xtal_ctl,
  output pll_ctl_t          pll_ctl,
  output freq_t             freq,
  output logic [LOCK_W-1:0] lock_cnt,
  output logic [DW-1:0]     prdata
);
  localparam logic [ADDR_W-1:0] A_XTAL = ADDR_W'(OFS_XTAL);
  localparam logic [ADDR_W-1:0] A_PLL  = ADDR_W'(OFS_PLL);
  localparam logic [ADDR_W-1:0] A_FREQ = ADDR_W'(OFS_FREQ);
  localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(OFS_LOCK);

  logic wr_stb;
  logic rd_stb;
  logic [DW-1:0] rd_val;

  assign wr_stb = psel & penable & pwrite;
  assign rd_stb = psel & ~pwrite;

  always_ff @(posedge clk) begin
    if (rst) begin
      xtal_ctl <= '{ovr: 1'b0, en: 1'b1, osc2_dis: 1'b0, tmr_en: 1'b0};
      pll_ctl  <= '{ovr: 1'b0, en: 1'b1, pll2_en: 1'b0, tmr_en: 1'b0};
      freq     <= '0;
      lock_cnt <= LOCK_W'(LOCK_RST);
    end else if (wr_stb) begin
      if (paddr == A_XTAL) begin
        xtal_ctl.ovr      <= pwdata[B_OVR];
        xtal_ctl.en       <= pwdata[B_EN];
        xtal_ctl.osc2_dis <= pwdata[B_OSC2_DIS];
        xtal_ctl.tmr_en   <= pwdata[B_XTMR];
      end
      if (paddr == A_PLL) begin
        pll_ctl.ovr     <= pwdata[B_OVR];
        pll_ctl.en      <= pwdata[B_EN];
        pll_ctl.pll2_en <= pwdata[B_PLL2_EN];
        pll_ctl.tmr_en  <= pwdata[B_PTMR];
      end
      if (paddr == A_FREQ) begin
        freq.m1 <= pwdata[F_M1 +: MW];
        freq.d1 <= pwdata[F_D1 +: SW];
        freq.m2 <= pwdata[F_M2 +: MW];
      end
      if (paddr == A_LOCK) begin
        lock_cnt <= pwdata[LOCK_W-1:0];
      end
    end
  end

  always_comb begin
    rd_val = '0;
    case (paddr)
      A_XTAL: begin
        rd_val[B_OVR]      = xtal_ctl.ovr;
        rd_val[B_EN]       = xtal_ctl.en;
        rd_val[B_RUN]      = run[SRC_XTAL];
        rd_val[B_OSC2_DIS] = xtal_ctl.osc2_dis;
        rd_val[B_XTMR]     = xtal_ctl.tmr_en;
      end
      A_PLL: begin
        rd_val[B_OVR]      = pll_ctl.ovr;
        rd_val[B_EN]       = pll_ctl.en;
        rd_val[B_RUN]      = run[SRC_PLL1];
        rd_val[B_PLL2_EN]  = pll_ctl.pll2_en;
        rd_val[B_PTMR]     = pll_ctl.tmr_en;
        rd_val[B_PLL2_RUN] = run[SRC_PLL2];
      end
      A_FREQ: begin
        rd_val[F_M1 +: MW] = freq.m1;
        rd_val[F_D1 +: SW] = freq.d1;
        rd_val[F_M2 +: MW] = freq.m2;
      end
      A_LOCK: rd_val[LOCK_W-1:0] = lock_cnt;
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) prdata <= '0;
    else if (rd_stb) prdata <= rd_val;
  end
endmodule

// File: rtl/opc_en_sel.sv
module opc_en_sel
  import opc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  xtal_ctl_t       xtal_ctl,
  input  pll_ctl_t        pll_ctl,
  input  logic            hw_xtal_req,
  input  logic            hw_pll1_req,
  output logic [NSRC-1:0] en_q
);
  logic [NSRC-1:0] en_d;

  always_comb begin
    en_d[SRC_XTAL] = xtal_ctl.ovr ? xtal_ctl.en : (hw_xtal_req | xtal_ctl.en);
    en_d[SRC_PLL1] = pll_ctl.ovr ? pll_ctl.en : hw_pll1_req;
    en_d[SRC_PLL2] = pll_ctl.pll2_en;
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_d;
  end
endmodule

// File: rtl/opc_lock_timer.sv
module opc_lock_timer #(
  parameter int LOCK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [LOCK_W-1:0] lock_cnt,
  output logic              run
);
  localparam logic [LOCK_W-1:0] CNT_MAX = '1;

  logic [LOCK_W-1:0] cnt;
  logic [LOCK_W-1:0] cnt_nx;

  assign cnt_nx = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      run <= 1'b0;
    end else begin
      cnt <= cnt_nx;
      run <= (cnt_nx >= lock_cnt);
    end
  end
endmodule

// File: rtl/osc_pll_ctrl.sv
module osc_pll_ctrl
  import opc_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int LOCK_W   = 8,
  parameter int LOCK_RST = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic              hw_xtal_req,
  input  logic              hw_pll1_req,
  output logic              xtal_en,
  output logic              pll1_en,
  output logic              pll2_en,
  output logic              osc2_dis,
  output logic              xtal_timer_en,
  output logic              pll_timer_en,
  output logic [6:0]        pll1_mul,
  output logic [2:0]        pll1_shift,
  output logic [6:0]        pll2_mul
);
  localparam logic [6:0] MUL_BIAS = 7'd2;

  xtal_ctl_t         xtal_ctl;
  pll_ctl_t          pll_ctl;
  freq_t             freq;
  logic [LOCK_W-1:0] lock_cnt;
  logic [NSRC-1:0]   en_q;
  logic [NSRC-1:0]   run;

  opc_regs #(.ADDR_W(ADDR_W), .LOCK_W(LOCK_W), .LOCK_RST(LOCK_RST)) i_regs (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .run(run), .xtal_ctl(xtal_ctl),
    .pll_ctl(pll_ctl), .freq(freq), .lock_cnt(lock_cnt), .prdata(prdata)
  );

  opc_en_sel i_en_sel (
    .clk(clk), .rst(rst), .xtal_ctl(xtal_ctl), .pll_ctl(pll_ctl),
    .hw_xtal_req(hw_xtal_req), .hw_pll1_req(hw_pll1_req), .en_q(en_q)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_lock
    opc_lock_timer #(.LOCK_W(LOCK_W)) i_timer (
      .clk(clk), .rst(rst), .en(en_q[g]), .lock_cnt(lock_cnt), .run(run[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pll1_mul   <= MUL_BIAS;
      pll1_shift <= '0;
      pll2_mul   <= MUL_BIAS;
    end else begin
      pll1_mul   <= {1'b0, freq.m1} + MUL_BIAS;
      pll1_shift <= freq.d1;
      pll2_mul   <= {1'b0, freq.m2} + MUL_BIAS;
    end
  end

  assign xtal_en       = en_q[SRC_XTAL];
  assign pll1_en       = en_q[SRC_PLL1];
  assign pll2_en       = en_q[SRC_PLL2];
  assign osc2_dis      = xtal_ctl.osc2_dis;
  assign xtal_timer_en = xtal_ctl.tmr_en;
  assign pll_timer_en  = pll_ctl.tmr_en;
endmodule

// File: rtl/osc_pll_ctrl_chk.sv
module osc_pll_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       xtal_ovr,
  input logic       xtal_sw,
  input logic       pll1_ovr,
  input logic       pll1_sw,
  input logic       pll2_sw,
  input logic       hw_xtal_req,
  input logic       hw_pll1_req,
  input logic       xtal_en,
  input logic       pll1_en,
  input logic       pll2_en,
  input logic [2:0] run,
  input logic [6:0] pll1_mul,
  input logic [6:0] pll2_mul
);
  logic seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  AST_XTAL_SELECT: assert property (@(posedge clk) disable iff (rst)
    seen |-> xtal_en == $past(xtal_ovr ? xtal_sw : (hw_xtal_req | xtal_sw))); // R2

  AST_PLL1_SELECT: assert property (@(posedge clk) disable iff (rst)
    seen |-> pll1_en == $past(pll1_ovr ? pll1_sw : hw_pll1_req)); // R3

  AST_PLL2_DIRECT: assert property (@(posedge clk) disable iff (rst)
    seen |-> pll2_en == $past(pll2_sw)); // R4

  AST_RUN_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    seen |-> (run & ~$past({pll2_en, pll1_en, xtal_en})) == 3'b000); // R5

  AST_MUL_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (pll1_mul >= 7'd2) && (pll2_mul >= 7'd2)); // R7
endmodule

bind osc_pll_ctrl osc_pll_ctrl_chk i_chk (
  .clk(clk), .rst(rst),
  .xtal_ovr(xtal_ctl.ovr), .xtal_sw(xtal_ctl.en),
  .pll1_ovr(pll_ctl.ovr), .pll1_sw(pll_ctl.en), .pll2_sw(pll_ctl.pll2_en),
  .hw_xtal_req(hw_xtal_req), .hw_pll1_req(hw_pll1_req),
  .xtal_en(xtal_en), .pll1_en(pll1_en), .pll2_en(pll2_en),
  .run(run), .pll1_mul(pll1_mul), .pll2_mul(pll2_mul)
);

// File: tb/test_osc_pll_ctrl.sv
module test_osc_pll_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int LW = 4;
  localparam int LRST = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic hw_xtal_req = 1'b0, hw_pll1_req = 1'b0;
  logic xtal_en, pll1_en, pll2_en, osc2_dis, xtal_timer_en, pll_timer_en;
  logic [6:0] pll1_mul, pll2_mul;
  logic [2:0] pll1_shift;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  osc_pll_ctrl #(.ADDR_W(AW), .LOCK_W(LW), .LOCK_RST(LRST)) i_osc_pll_ctrl (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .hw_xtal_req(hw_xtal_req), .hw_pll1_req(hw_pll1_req),
    .xtal_en(xtal_en), .pll1_en(pll1_en), .pll2_en(pll2_en),
    .osc2_dis(osc2_dis), .xtal_timer_en(xtal_timer_en), .pll_timer_en(pll_timer_en),
    .pll1_mul(pll1_mul), .pll1_shift(pll1_shift), .pll2_mul(pll2_mul)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    tick(1);
    penable = 1'b1;
    tick(1);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    tick(1);
    penable = 1'b1;
    d = prdata;
    tick(1);
    psel = 1'b0; penable = 1'b0;
  endtask

  // Measures cycles from a hardware request edge to the running bit change (R5)
  task automatic lock_sweep(input int src, input int lk);
    logic [AW-1:0] a;
    int first_up, first_dn;
    a = (src == 0) ? AW'('h0C) : AW'('h10);
    bus_wr(AW'('h18), 32'(lk));
    bus_wr(a, 32'h0);
    hw_xtal_req = 1'b0; hw_pll1_req = 1'b0;
    tick(20);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b1; paddr = a;
    if (src == 0) hw_xtal_req = 1'b1; else hw_pll1_req = 1'b1;
    first_up = 0;
    for (int j = 1; j <= 20; j++) begin
      tick(1);
      if (j == 1) check("R2/R3 enable follows request", 32'(src == 0 ? xtal_en : pll1_en), 32'd1);
      if (first_up == 0 && prdata[2]) first_up = j;
    end
    check($sformatf("R5 rise src%0d lock%0d", src, lk), 32'(first_up),
          32'(2 + ((lk < 1) ? 1 : lk)));
    hw_xtal_req = 1'b0; hw_pll1_req = 1'b0;
    first_dn = 0;
    for (int j = 1; j <= 6; j++) begin
      tick(1);
      if (first_dn == 0 && !prdata[2]) first_dn = j;
    end
    check($sformatf("R5 fall src%0d lock%0d", src, lk), 32'(first_dn), 32'd3);
    psel = 1'b0; penable = 1'b0;
    tick(1);
  endtask

  initial begin
    logic [31:0] rd;
    tick(3);
    check("R1 xtal_en in reset", 32'(xtal_en), 32'd0);
    rst = 1'b0;
    tick(1);
    check("R1 pll2_en", 32'(pll2_en), 32'd0);
    check("R1 pll1_mul", 32'(pll1_mul), 32'd2);
    check("R1 pll2_mul", 32'(pll2_mul), 32'd2);
    bus_rd(AW'('h0C), rd); check("R1 xtal reg", rd & ~32'h4, 32'h2);
    bus_rd(AW'('h10), rd); check("R1 pll reg", rd & ~32'h4000_0004, 32'h2);
    bus_rd(AW'('h14), rd); check("R1 freq reg", rd, 32'h0);
    bus_rd(AW'('h18), rd); check("R1 lock reg", rd, 32'(LRST));

    // R2 R3 R4: all combinations of override, enable, request, pll2 bit
    for (int c = 0; c < 16; c++) begin
      logic ov, en, hw, p2;
      {p2, hw, en, ov} = 4'(c);
      bus_wr(AW'('h0C), {30'd0, en, ov});
      bus_wr(AW'('h10), {3'd0, p2, 26'd0, en, ov});
      hw_xtal_req = hw; hw_pll1_req = hw;
      tick(2);
      check("R2 xtal select", 32'(xtal_en), 32'(ov ? en : (hw | en)));
      check("R3 pll1 select", 32'(pll1_en), 32'(ov ? en : hw));
      check("R4 pll2 direct", 32'(pll2_en), 32'(p2));
    end

    // R5 lock timing for every lock value
    for (int lk = 0; lk < 16; lk++) begin
      lock_sweep(0, lk);
      lock_sweep(1, lk);
    end

    // R5 PLL2 running bit (bit 30)
    bus_wr(AW'('h18), 32'd2);
    bus_wr(AW'('h10), 32'h1000_0000);
    tick(6);
    bus_rd(AW'('h10), rd); check("R5 pll2 running", 32'(rd[30]), 32'd1);
    bus_wr(AW'('h10), 32'h0);
    tick(3);
    bus_rd(AW'('h10), rd); check("R5 pll2 stopped", 32'(rd[30]), 32'd0);

    // R6 running bits read-only
    hw_xtal_req = 1'b0; hw_pll1_req = 1'b0;
    bus_wr(AW'('h0C), 32'h5);
    bus_wr(AW'('h10), 32'h4000_0004);
    tick(6);
    bus_rd(AW'('h0C), rd); check("R6 xtal running bit write ignored", rd, 32'h1);
    bus_rd(AW'('h10), rd); check("R6 pll running bits write ignored", rd, 32'h0);

    // R8 misc bits
    bus_wr(AW'('h0C), 32'h0018_0001);
    bus_wr(AW'('h10), 32'h2000_0000);
    tick(1);
    check("R8 osc2_dis", 32'(osc2_dis), 32'd1);
    check("R8 xtal_timer_en", 32'(xtal_timer_en), 32'd1);
    check("R8 pll_timer_en", 32'(pll_timer_en), 32'd1);
    bus_rd(AW'('h0C), rd); check("R8 xtal readback", rd, 32'h0018_0001);
    bus_rd(AW'('h10), rd); check("R8 pll readback", rd & ~32'h4000_0004, 32'h2000_0000);

    // R9 lock register width
    bus_wr(AW'('h18), 32'hFFFF_FFFF);
    bus_rd(AW'('h18), rd); check("R9 lock readback", rd, 32'h0000_000F);

    // R10 unmapped and reserved bits
    bus_wr(AW'('h20), 32'hFFFF_FFFF);
    bus_rd(AW'('h20), rd); check("R10 unmapped read", rd, 32'h0);
    bus_rd(AW'('h0C), rd); check("R10 unmapped write no effect", rd, 32'h0018_0001);
    bus_rd(AW'('h00), rd); check("R10 offset 0 read", rd, 32'h0);
    bus_wr(AW'('h0C), 32'hFFFF_FFFF);
    bus_rd(AW'('h0C), rd); check("R10 xtal reserved bits", rd & ~32'h4, 32'h0018_0003);
    bus_wr(AW'('h14), 32'hFFFF_FFFF);
    bus_rd(AW'('h14), rd); check("R10 freq reserved bits", rd, 32'h3F00_3F07);

    // R7 frequency decode sweep
    for (int f = 0; f < 64; f++) begin
      logic [31:0] wv;
      wv = (32'(63 - f) << 24) | (32'(f) << 8) | 32'(f % 8);
      bus_wr(AW'('h14), wv);
      tick(1);
      check("R7 pll1_mul", 32'(pll1_mul), 32'(f + 2));
      check("R7 pll1_shift", 32'(pll1_shift), 32'(f % 8));
      check("R7 pll2_mul", 32'(pll2_mul), 32'(63 - f + 2));
      if (f % 16 == 5) begin
        bus_rd(AW'('h14), rd); check("R7 freq readback", rd, wv);
      end
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule